// File: doc/BRIEF.md
# E1 Timeslot-Zero Overhead Capture

This block sits behind an E1 framer that has already found frame alignment. It samples the received serial stream on bit-enable cycles and captures the overhead carried at the head of each frame. Two 8-bit snapshot registers result. The first holds the leading eight bits of the latest frame that carries no alignment word. The second holds the international (Si) bits taken from the eight alignment frames of the last complete CRC-4 multiframe.

Both snapshots are built in shadow storage. They become visible only at a frame or multiframe boundary, so a reader always sees one consistent set of bits and never a mix of frames. The framer supplies the frame-start and multiframe-start markers, a flag telling alignment frames from the others, and an alignment-good level. One-cycle strobes report each register load and each boundary.

Top module: `e1_ts0_capture`

## Requirements
- R1: After reset, `nas_reg` and `si_reg` read 0x00 and every strobe output is low.
- R2: Data is sampled only on cycles with `bit_en` high. The first eight bits of a non-align frame land MSB first. The first bit received goes to bit 7 (Si). The second goes to bit 6, the fixed bit that reads 1 in a normal double frame. The third goes to bit 5 (remote alarm, 1 = alarm). The last five go to bits 4..0, which are Sa4..Sa8 in that order.
- R3: `nas_reg` changes only one clock after a bit that carries `frm_start` with `fas_frame` high. `nas_upd` is high in that same cycle. No update happens inside a non-align frame.
- R4: A non-align capture is published only if all eight of its bits arrived since the last publication. A header cut short by an early frame start leaves `nas_reg` unchanged.
- R5: Bit k of `si_reg` is the first bit of the align frame with index 2k in the multiframe. Frame 0 is the frame whose start bit carries `mf_start`.
- R6: `si_reg` loads only one clock after a bit that carries both `frm_start` and `mf_start`, and `si_upd` is high in that cycle. `mf_start` without `frm_start` has no effect.
- R7: While `sync_ok` is low, nothing is published, no pulse is emitted and any partial capture is discarded. After alignment returns, capture restarts at the next frame start.
- R8: `nas_upd` and `si_upd` are each high for a single cycle per load.
- R9: `af_pulse` is high one clock after an aligned align-frame start bit. `mf_pulse` is high one clock after an aligned multiframe start bit.
- R10: The Si snapshot is published only if all eight align frames of the preceding multiframe were captured after its start, with alignment held throughout. The first multiframe after alignment returns is not published, and neither is a multiframe cut short by an early multiframe start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One cycle per received bit |
| rx_bit | input | 1 | Received serial data, valid with `bit_en` |
| frm_start | input | 1 | Current bit is the first of a frame |
| mf_start | input | 1 | Current frame starts a CRC-4 multiframe (valid with `frm_start`) |
| fas_frame | input | 1 | Current frame carries the alignment word (valid with `frm_start`) |
| sync_ok | input | 1 | Framer reports frame alignment |
| nas_reg | output | 8 | Non-align frame header snapshot |
| nas_upd | output | 1 | `nas_reg` loaded this cycle |
| si_reg | output | 8 | Si bits of last complete multiframe |
| si_upd | output | 1 | `si_reg` loaded this cycle |
| af_pulse | output | 1 | Align frame started |
| mf_pulse | output | 1 | Multiframe started |

## Verification
The assertions check on every cycle that:
- each snapshot holds still unless its strobe fires;
- each strobe follows the matching boundary and lasts a single cycle;
- the boundary pulses track the framer markers one clock later;
- nothing is published in the cycle after alignment was lost.

Only the bench scenarios can show the content of the registers. Those scenarios cover the bit order in both registers, the frame-index mapping of the Si bits, and the choice of the most recent non-align frame. They also show that truncated headers, the first multiframe after realignment and a multiframe cut short are all withheld.

// File: rtl/e1oh_pkg.sv
package e1oh_pkg;

  // Per-bit events decoded by the frame tracker and consumed by the capture units.
  typedef struct packed {
    logic bit_v;      // in-frame bit accepted while aligned
    logic fas_start;  // first bit of an align frame
    logic mf_begin;   // first bit of a multiframe
    logic drop;       // alignment absent
  } frm_evt_t;

endpackage

// File: rtl/e1oh_frame_track.sv
module e1oh_frame_track
  import e1oh_pkg::*;
#(
  parameter int OH_BITS   = 8,
  parameter int MF_FRAMES = 16,
  localparam int PW = $clog2(OH_BITS + 1),
  localparam int FW = $clog2(MF_FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          frm_start,
  input  logic          mf_start,
  input  logic          fas_frame,
  input  logic          sync_ok,
  output frm_evt_t      evt,
  output logic [PW-1:0] cur_pos,
  output logic          cur_fas,
  output logic [FW-1:0] cur_fidx,
  output logic          cur_mfk,
  output logic          af_pulse,
  output logic          mf_pulse
);

  logic [PW-1:0] pos_q;
  logic          fas_q;
  logic [FW-1:0] fidx_q;
  logic          mfk_q;
  logic          fok_q;
  logic          mfs;

  assign mfs = frm_start & mf_start;

  always_comb begin
    cur_pos       = frm_start ? '0 : pos_q;
    cur_fas       = frm_start ? fas_frame : fas_q;
    if (mfs)
      cur_fidx = '0;
    else if (frm_start)
      cur_fidx = (fidx_q == FW'(MF_FRAMES - 1)) ? '0 : fidx_q + FW'(1);
    else
      cur_fidx = fidx_q;
    cur_mfk       = sync_ok & (mfk_q | mfs);
    evt.bit_v     = bit_en & sync_ok & (fok_q | frm_start);
    evt.fas_start = bit_en & sync_ok & frm_start & fas_frame;
    evt.mf_begin  = bit_en & sync_ok & mfs;
    evt.drop      = ~sync_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      fas_q    <= 1'b0;
      fidx_q   <= '0;
      mfk_q    <= 1'b0;
      fok_q    <= 1'b0;
      af_pulse <= 1'b0;
      mf_pulse <= 1'b0;
    end else begin
      af_pulse <= evt.fas_start;
      mf_pulse <= evt.mf_begin;
      if (!sync_ok) begin
        pos_q  <= '0;
        fas_q  <= 1'b0;
        fidx_q <= '0;
        mfk_q  <= 1'b0;
        fok_q  <= 1'b0;
      end else if (bit_en) begin
        if (frm_start) fok_q <= 1'b1;
        pos_q  <= (cur_pos < PW'(OH_BITS)) ? cur_pos + PW'(1) : cur_pos;
        fas_q  <= cur_fas;
        fidx_q <= cur_fidx;
        mfk_q  <= cur_mfk;
      end
    end
  end

  a_r9_pulse_track: assert property (@(posedge clk) disable iff (rst)
    af_pulse == $past(bit_en & frm_start & fas_frame & sync_ok));
  a_r9_mf_track: assert property (@(posedge clk) disable iff (rst)
    mf_pulse == $past(bit_en & frm_start & mf_start & sync_ok));

endmodule

// File: rtl/e1oh_nas_cap.sv
module e1oh_nas_cap
  import e1oh_pkg::*;
#(
  parameter int OH_BITS = 8,
  localparam int PW = $clog2(OH_BITS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  frm_evt_t           evt,
  input  logic [PW-1:0]      cur_pos,
  input  logic               cur_fas,
  input  logic               rx_bit,
  output logic [OH_BITS-1:0] nas_reg,
  output logic               nas_upd
);

  logic [OH_BITS-1:0] shadow;
  logic               full_q;
  logic               take;

  assign take = evt.bit_v & ~cur_fas & (cur_pos < PW'(OH_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      full_q  <= 1'b0;
      nas_reg <= '0;
      nas_upd <= 1'b0;
    end else begin
      nas_upd <= 1'b0;
      if (evt.drop) begin
        full_q <= 1'b0;
      end else begin
        if (evt.fas_start && full_q) begin
          nas_reg <= shadow;
          nas_upd <= 1'b1;
          full_q  <= 1'b0;
        end
        if (take) begin
          shadow <= {shadow[OH_BITS-2:0], rx_bit};
          if (cur_pos == '0)                 full_q <= 1'b0;
          if (cur_pos == PW'(OH_BITS - 1))   full_q <= 1'b1;
        end
      end
    end
  end

  a_r3_nas_hold: assert property (@(posedge clk) disable iff (rst)
    !nas_upd |-> $stable(nas_reg));
  a_r3_nas_at_align: assert property (@(posedge clk) disable iff (rst)
    nas_upd |-> $past(evt.fas_start));
  a_r8_nas_single: assert property (@(posedge clk) disable iff (rst)
    nas_upd |=> !nas_upd);

endmodule

// File: rtl/e1oh_si_cap.sv
module e1oh_si_cap
  import e1oh_pkg::*;
#(
  parameter int OH_BITS   = 8,
  parameter int MF_FRAMES = 16,
  localparam int PW   = $clog2(OH_BITS + 1),
  localparam int FW   = $clog2(MF_FRAMES),
  localparam int SI_N = MF_FRAMES / 2,
  localparam int SW   = FW - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  frm_evt_t        evt,
  input  logic [PW-1:0]   cur_pos,
  input  logic            cur_fas,
  input  logic [FW-1:0]   cur_fidx,
  input  logic            cur_mfk,
  input  logic            rx_bit,
  output logic [SI_N-1:0] si_reg,
  output logic            si_upd
);

  logic [SI_N-1:0] shadow;
  logic [SI_N-1:0] seen;
  logic [SW-1:0]   slot;
  logic            wr;

  assign slot = cur_fidx[FW-1:1];
  assign wr   = evt.bit_v & cur_fas & (cur_pos == '0) & cur_mfk;

  for (genvar g = 0; g < SI_N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[g] <= 1'b0;
        seen[g]   <= 1'b0;
      end else if (evt.drop) begin
        seen[g]   <= 1'b0;
      end else if (wr && slot == SW'(g)) begin
        shadow[g] <= rx_bit;
        seen[g]   <= 1'b1;
      end else if (evt.mf_begin) begin
        seen[g]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      si_reg <= '0;
      si_upd <= 1'b0;
    end else begin
      si_upd <= 1'b0;
      if (evt.mf_begin && (&seen)) begin
        si_reg <= shadow;
        si_upd <= 1'b1;
      end
    end
  end

  a_r6_si_hold: assert property (@(posedge clk) disable iff (rst)
    !si_upd |-> $stable(si_reg));
  a_r6_si_at_mf: assert property (@(posedge clk) disable iff (rst)
    si_upd |-> $past(evt.mf_begin));
  a_r8_si_single: assert property (@(posedge clk) disable iff (rst)
    si_upd |=> !si_upd);

endmodule

// File: rtl/e1_ts0_capture.sv
module e1_ts0_capture
  import e1oh_pkg::*;
#(
  parameter int OH_BITS   = 8,
  parameter int MF_FRAMES = 16,
  localparam int PW   = $clog2(OH_BITS + 1),
  localparam int FW   = $clog2(MF_FRAMES),
  localparam int SI_N = MF_FRAMES / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               rx_bit,
  input  logic               frm_start,
  input  logic               mf_start,
  input  logic               fas_frame,
  input  logic               sync_ok,
  output logic [OH_BITS-1:0] nas_reg,
  output logic               nas_upd,
  output logic [SI_N-1:0]    si_reg,
  output logic               si_upd,
  output logic               af_pulse,
  output logic               mf_pulse
);

  frm_evt_t      evt;
  logic [PW-1:0] cur_pos;
  logic          cur_fas;
  logic [FW-1:0] cur_fidx;
  logic          cur_mfk;

  e1oh_frame_track #(.OH_BITS(OH_BITS), .MF_FRAMES(MF_FRAMES)) u_track (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frm_start(frm_start),
    .mf_start(mf_start), .fas_frame(fas_frame), .sync_ok(sync_ok),
    .evt(evt), .cur_pos(cur_pos), .cur_fas(cur_fas), .cur_fidx(cur_fidx),
    .cur_mfk(cur_mfk), .af_pulse(af_pulse), .mf_pulse(mf_pulse)
  );

  e1oh_nas_cap #(.OH_BITS(OH_BITS)) u_nas (
    .clk(clk), .rst(rst), .evt(evt), .cur_pos(cur_pos), .cur_fas(cur_fas),
    .rx_bit(rx_bit), .nas_reg(nas_reg), .nas_upd(nas_upd)
  );

  e1oh_si_cap #(.OH_BITS(OH_BITS), .MF_FRAMES(MF_FRAMES)) u_si (
    .clk(clk), .rst(rst), .evt(evt), .cur_pos(cur_pos), .cur_fas(cur_fas),
    .cur_fidx(cur_fidx), .cur_mfk(cur_mfk), .rx_bit(rx_bit),
    .si_reg(si_reg), .si_upd(si_upd)
  );

  a_r7_quiet_unaligned: assert property (@(posedge clk) disable iff (rst)
    !$past(sync_ok) |-> (!nas_upd && !si_upd && !af_pulse && !mf_pulse));
  a_r9_nas_with_af: assert property (@(posedge clk) disable iff (rst)
    nas_upd |-> af_pulse);
  a_r9_si_with_mf: assert property (@(posedge clk) disable iff (rst)
    si_upd |-> mf_pulse);

endmodule

// File: tb/sim_e1_ts0_capture.sv
`timescale 1ns/1ps
module sim_e1_ts0_capture;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, rx_bit = 1'b0, frm_start = 1'b0, mf_start = 1'b0;
  logic fas_frame = 1'b0, sync_ok = 1'b0;
  logic [7:0] nas_reg, si_reg;
  logic nas_upd, si_upd, af_pulse, mf_pulse;

  int checks = 0;
  int fails  = 0;
  logic saw_nas, saw_si, saw_af, saw_mf;
  logic [7:0] exp_nas, exp_si, prev_byte;

  // {non-align header, Si pattern}; 0xE5 = Si 1, fixed 1, alarm 1, Sa 00101
  localparam logic [15:0] VEC [0:7] = '{
    16'hE5_96, 16'h40_01, 16'h7F_80, 16'hC0_FF,
    16'h5F_00, 16'h60_3C, 16'hDB_A5, 16'h4A_C3
  };

  always #4 clk = ~clk;

  e1_ts0_capture u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .frm_start(frm_start), .mf_start(mf_start), .fas_frame(fas_frame),
    .sync_ok(sync_ok), .nas_reg(nas_reg), .nas_upd(nas_upd),
    .si_reg(si_reg), .si_upd(si_upd), .af_pulse(af_pulse), .mf_pulse(mf_pulse)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic checkb(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic fs, input logic ms, input logic fa);
    @(negedge clk);
    bit_en = 1'b1; rx_bit = b; frm_start = fs; mf_start = ms; fas_frame = fa;
    @(negedge clk);
    bit_en = 1'b0; rx_bit = ~b; frm_start = 1'b0; mf_start = 1'b0; fas_frame = 1'b0;
    saw_nas |= nas_upd; saw_si |= si_upd; saw_af |= af_pulse; saw_mf |= mf_pulse;
  endtask

  task automatic send_frame(input logic fa, input logic ms, input logic [7:0] head, input int nbits);
    saw_nas = 1'b0; saw_si = 1'b0; saw_af = 1'b0; saw_mf = 1'b0;
    for (int i = 0; i < nbits; i++)
      send_bit((i < 8) ? head[7-i] : logic'(i % 2), i == 0, ms && i == 0, fa);
  endtask

  // frames first..last of a multiframe, Si taken from pat, no checks
  task automatic send_frames(input logic [7:0] pat, input int first, input int last);
    for (int f = first; f <= last; f++) begin
      if (f % 2 == 0) send_frame(1'b1, 1'b0, {pat[f/2], 7'h15}, 12);
      else            send_frame(1'b0, 1'b0, 8'hC3, 12);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check8("R1 nas reset", nas_reg, 8'h00);
    check8("R1 si reset", si_reg, 8'h00);
    checkb("R1 strobes reset", nas_upd | si_upd | af_pulse | mf_pulse, 1'b0);
    sync_ok = 1'b1;
    exp_nas = 8'h00; exp_si = 8'h00; prev_byte = 8'h00;

    // table walk: eight multiframes, then the closing multiframe start
    for (int k = 0; k <= 8; k++) begin
      for (int f = 0; f < ((k == 8) ? 1 : 16); f++) begin
        if (f % 2 == 0) begin
          logic sib;
          sib = (k == 8) ? 1'b0 : VEC[k][f/2];
          send_frame(1'b1, f == 0, {sib, 7'h2A}, 12);
          checkb("R9 af_pulse", saw_af, 1'b1);
          checkb("R9 mf_pulse", saw_mf, f == 0);
          if (k == 0 && f == 0) begin
            checkb("R4 no nas before any capture", saw_nas, 1'b0);
            check8("R4 nas held", nas_reg, 8'h00);
            checkb("R10 first multiframe not published", saw_si, 1'b0);
            check8("R10 si held", si_reg, 8'h00);
          end else begin
            exp_nas = prev_byte;
            checkb("R3 nas_upd at align start", saw_nas, 1'b1);
            check8("R2 nas content", nas_reg, exp_nas);
            if (f == 0) begin
              exp_si = VEC[k-1][7:0];
              checkb("R6 si_upd at multiframe start", saw_si, 1'b1);
              check8("R5 si content", si_reg, exp_si);
            end else begin
              checkb("R6 no si_upd mid multiframe", saw_si, 1'b0);
            end
          end
          checkb("R8 nas_upd single", nas_upd, 1'b0);
        end else begin
          prev_byte = (f == 15) ? VEC[k][15:8] : (VEC[k][15:8] ^ 8'(f));
          send_frame(1'b0, 1'b0, prev_byte, 12);
          checkb("R3 no nas_upd in non-align frame", saw_nas, 1'b0);
          check8("R3 nas stable in non-align frame", nas_reg, exp_nas);
        end
      end
    end

    // truncated non-align header (frames 1..4 of the open multiframe)
    send_frame(1'b0, 1'b0, 8'hA5, 5);
    send_frame(1'b1, 1'b0, 8'h00, 12);
    checkb("R4 truncated header not published", saw_nas, 1'b0);
    check8("R4 nas held after truncation", nas_reg, exp_nas);
    send_frame(1'b0, 1'b0, 8'h3C, 12);
    send_frame(1'b1, 1'b0, 8'h00, 12);
    exp_nas = 8'h3C;
    checkb("R3 nas_upd after full header", saw_nas, 1'b1);
    check8("R2 nas after full header", nas_reg, exp_nas);

    // alignment loss
    sync_ok = 1'b0;
    send_frame(1'b1, 1'b1, 8'hFF, 6);
    checkb("R7 no strobes while unaligned", saw_nas | saw_si | saw_af | saw_mf, 1'b0);
    send_frame(1'b0, 1'b0, 8'h11, 12);
    send_frame(1'b1, 1'b0, 8'h11, 12);
    checkb("R7 no strobes while unaligned 2", saw_nas | saw_si | saw_af | saw_mf, 1'b0);
    check8("R7 nas held unaligned", nas_reg, exp_nas);
    check8("R7 si held unaligned", si_reg, exp_si);
    sync_ok = 1'b1;
    send_frame(1'b0, 1'b0, 8'h77, 12);
    send_frame(1'b1, 1'b0, 8'h00, 12);
    exp_nas = 8'h77;
    checkb("R7 capture resumes", saw_nas, 1'b1);
    check8("R7 nas after realign", nas_reg, exp_nas);
    send_frame(1'b1, 1'b1, 8'h00, 12);
    checkb("R10 partial after realign not published", saw_si, 1'b0);
    check8("R10 si held after realign", si_reg, exp_si);
    send_frames(8'h5A, 1, 15);
    send_frame(1'b1, 1'b1, 8'h80, 12);
    exp_si = 8'h5A;
    checkb("R6 si_upd after full multiframe", saw_si, 1'b1);
    check8("R5 si after realign", si_reg, exp_si);

    // multiframe cut short at frame 8
    send_frames(8'hFF, 1, 7);
    send_frame(1'b1, 1'b1, 8'h80, 12);
    checkb("R10 cut-short multiframe not published", saw_si, 1'b0);
    check8("R10 si held after cut-short", si_reg, exp_si);
    send_frames(8'h81, 1, 15);
    send_frame(1'b1, 1'b1, 8'h00, 12);
    exp_si = 8'h81;
    checkb("R6 si_upd after recovery", saw_si, 1'b1);
    check8("R5 si after recovery", si_reg, exp_si);

    // multiframe marker without frame start is ignored
    saw_si = 1'b0; saw_mf = 1'b0;
    send_bit(1'b1, 1'b0, 1'b1, 1'b0);
    checkb("R6 mf_start without frame start ignored", saw_si | saw_mf, 1'b0);
    check8("R6 si held", si_reg, exp_si);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule